// File: doc/BRIEF.md
# Valid-Bit Ring Enqueue Producer

This block is the producer half of a circular command ring that carries enqueue descriptors to a downstream queue engine. A client hands it a batch request: a count, one shared header template (command word, acknowledgement byte, header body) and a per-frame table of frame descriptors and flags, which the block reads through an index it drives. The block decides how many frames fit in the ring and writes one slot per accepted frame into an external slot memory. It then publishes its new producer position with a single register write.

Slot ownership is not tracked with full/empty flags. The producer and consumer indexes count over twice the ring depth, so free space is the wrapped distance between them. Each slot's command word carries a phase bit that flips every time the producer passes the end of the ring. The consumer index is an input. The block samples it only when its cached free count has run out. All body writes of a batch land before any command word is written, so the consumer never sees a live command word over a stale body.

Top module: `rvb_enq_top`

## Requirements
- R1: On synchronous reset the producer index takes the low log2(DEPTH)+1 bits of `init_pi`, the phase bit takes `init_pi[7]`, the cached consumer index takes the low log2(DEPTH)+1 bits of `init_ci`, and the cached free count becomes DEPTH. After reset `req_ready` is 1 and `done`, `body_we`, `head_we` and `pub_we` are 0.
- R2: When the consumer index is sampled, the new free count is the distance from the cached index (included) to the sampled one (excluded). It is new minus old when old is not greater than new, and otherwise 2*DEPTH minus (old minus new).
- R3: `ci_in` is sampled only at a request accepted while the cached free count is zero. If the recomputed count is still zero, the batch completes with `done_count` 0, no slot writes and no publish write.
- R4: The accepted count is the smaller of the free count and `req_count`. The cached free count is reduced by the accepted count.
- R5: Each accepted frame k (k from 0) gets one body write, in order. The write goes to slot (pi+k) mod DEPTH, with `body_data` = {`hdr_body`, `frm_fd`} while `frm_idx` = k.
- R6: Command-word writes of a batch start only after all of its body writes, with one command-word write per accepted frame, in the same slot order.
- R7: The command word is `hdr_cmd` ORed with the phase bit at bit 7. The producer index steps once per command-word write. The phase flips whenever the low log2(DEPTH) bits of the stepped index become zero.
- R8: The acknowledgement byte of a slot is 0x80 ORed with `frm_flag[3:0]` when `frm_flag[31]` is 1, and `hdr_ack` otherwise.
- R9: A batch with at least one accepted frame ends with one `pub_we` pulse, in the same cycle as `done`. `pub_data` is 0x100 ORed with the new producer index and the phase bit at bit 7.
- R10: `req_ready` is 1 only while no batch is running. `done` is a one-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the initial register values |
| init_pi | input | 32 | Initial producer register value (index and phase bit 7) |
| init_ci | input | 32 | Initial consumer register value |
| req_valid | input | 1 | Batch request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_count | input | CNT_W | Frames requested |
| hdr_cmd | input | 32 | Template command word |
| hdr_ack | input | 8 | Template acknowledgement byte |
| hdr_body | input | HDR_BODY_W | Template header body (after the command word) |
| ci_in | input | 32 | Current consumer index |
| frm_idx | output | CNT_W | Frame table index being read |
| frm_fd | input | FD_W | Frame descriptor of frame frm_idx |
| frm_flag | input | 32 | Per-frame flag of frame frm_idx |
| body_we | output | 1 | Slot body write strobe |
| head_we | output | 1 | Slot command-word write strobe |
| slot | output | log2(DEPTH) | Slot address of the current write |
| body_data | output | HDR_BODY_W+FD_W | Body: header body above, descriptor below |
| head_cmd | output | 32 | Command word with phase bit |
| head_ack | output | 8 | Acknowledgement byte |
| pub_we | output | 1 | Producer register write strobe |
| pub_data | output | 32 | Producer register value |
| done | output | 1 | Batch complete pulse |
| done_count | output | CNT_W | Frames accepted in the batch |

## Verification
A vector table drives batches that fit entirely, batches clipped by the free count, a request made with the ring full (zero accepted, no publish), a request of zero frames, and a batch that fills the whole ring after a full drain. Together they separate the min rule from the wrapped-distance rule and show whether the consumer index is read too often. The consumer value offered while free space remains is deliberately bogus, so any early resampling changes the accepted counts. Flag patterns alternate the acknowledgement override per frame. A second reset start just below the top of the index space forces both the slot wrap and the phase flip inside one batch.

// File: rtl/rvb_pkg.sv
package rvb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_HEAD = 2'd2,
    ST_FIN  = 2'd3
  } rvb_state_e;

  localparam logic [31:0] PUB_TAG     = 32'h0000_0100;
  localparam int unsigned VB_POS      = 7;
  localparam int unsigned ACK_EN_BIT  = 31;

  // Wrapped distance: first included, last excluded, indexes over 2*depth.
  function automatic int unsigned ring_gap(int unsigned first, int unsigned last,
                                           int unsigned depth);
    if (first <= last) return last - first;
    return (2 * depth) - (first - last);
  endfunction

  function automatic int unsigned take_min(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

  function automatic logic [7:0] ack_byte(logic [31:0] flag, logic [7:0] dflt);
    if (flag[ACK_EN_BIT]) return {1'b1, 3'b000, flag[3:0]};
    return dflt;
  endfunction

endpackage

// File: rtl/rvb_space.sv
module rvb_space
  import rvb_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] init_ci,
  input  logic             start,
  input  logic [IDX_W-1:0] ci_in,
  input  logic [CNT_W-1:0] want,
  output logic [CNT_W-1:0] grant,
  output logic             resample
);

  logic [IDX_W-1:0] ci_q;
  logic [IDX_W-1:0] avail_q;
  logic [IDX_W-1:0] eff;

  assign resample = start && (avail_q == '0);

  always_comb begin
    if (resample) eff = IDX_W'(ring_gap(32'(ci_q), 32'(ci_in), DEPTH));
    else          eff = avail_q;
    grant = CNT_W'(take_min(32'(eff), 32'(want)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ci_q    <= init_ci;
      avail_q <= IDX_W'(DEPTH);
    end else if (start) begin
      if (resample) ci_q <= ci_in;
      avail_q <= eff - IDX_W'(grant);
    end
  end

endmodule

// File: rtl/rvb_phase.sv
module rvb_phase #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned SLOT_W = $clog2(DEPTH),
  localparam int unsigned IDX_W  = SLOT_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] init_idx,
  input  logic             init_vb,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             vb,
  output logic             wrap
);

  logic [IDX_W-1:0] nxt;

  assign nxt  = idx + 1'b1;
  assign wrap = step && (nxt[SLOT_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= init_idx;
      vb  <= init_vb;
    end else if (step) begin
      idx <= nxt;
      if (wrap) vb <= ~vb;
    end
  end

endmodule

// File: rtl/rvb_enq_top.sv
module rvb_enq_top
  import rvb_pkg::*;
#(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned HDR_BODY_W = 200,
  parameter int unsigned FD_W       = 256,
  localparam int unsigned SLOT_W = $clog2(DEPTH),
  localparam int unsigned IDX_W  = SLOT_W + 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [31:0]                init_pi,
  input  logic [31:0]                init_ci,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [CNT_W-1:0]           req_count,
  input  logic [31:0]                hdr_cmd,
  input  logic [7:0]                 hdr_ack,
  input  logic [HDR_BODY_W-1:0]      hdr_body,
  input  logic [31:0]                ci_in,
  output logic [CNT_W-1:0]           frm_idx,
  input  logic [FD_W-1:0]            frm_fd,
  input  logic [31:0]                frm_flag,
  output logic                       body_we,
  output logic                       head_we,
  output logic [SLOT_W-1:0]          slot,
  output logic [HDR_BODY_W+FD_W-1:0] body_data,
  output logic [31:0]                head_cmd,
  output logic [7:0]                 head_ack,
  output logic                       pub_we,
  output logic [31:0]                pub_data,
  output logic                       done,
  output logic [CNT_W-1:0]           done_count
);

  rvb_state_e       state_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] k_q;
  logic             accept;
  logic             last_k;
  logic [CNT_W-1:0] grant;

  // Named internal events, visible to the bound checker.
  logic             ev_resample;
  logic             ev_wrap;
  logic [IDX_W-1:0] pi_now;
  logic             vb_now;
  logic             unused_ok;

  assign unused_ok = ^{init_pi, init_ci, ci_in, frm_flag};

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign last_k    = (k_q == n_q - 1'b1);

  rvb_space #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_space (
    .clk      (clk),
    .rst      (rst),
    .init_ci  (init_ci[IDX_W-1:0]),
    .start    (accept),
    .ci_in    (ci_in[IDX_W-1:0]),
    .want     (req_count),
    .grant    (grant),
    .resample (ev_resample)
  );

  rvb_phase #(.DEPTH(DEPTH)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .init_idx (init_pi[IDX_W-1:0]),
    .init_vb  (init_pi[VB_POS]),
    .step     (head_we),
    .idx      (pi_now),
    .vb       (vb_now),
    .wrap     (ev_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      n_q     <= '0;
      k_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          n_q     <= grant;
          k_q     <= '0;
          state_q <= (grant == '0) ? ST_FIN : ST_BODY;
        end
        ST_BODY: begin
          if (last_k) begin
            k_q     <= '0;
            state_q <= ST_HEAD;
          end else begin
            k_q <= k_q + 1'b1;
          end
        end
        ST_HEAD: begin
          if (last_k) state_q <= ST_FIN;
          else        k_q     <= k_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    body_we    = (state_q == ST_BODY);
    head_we    = (state_q == ST_HEAD);
    done       = (state_q == ST_FIN);
    pub_we     = done && (n_q != '0);
    done_count = n_q;
    frm_idx    = k_q;
    if (body_we) slot = SLOT_W'(pi_now + IDX_W'(k_q));
    else         slot = pi_now[SLOT_W-1:0];
    body_data  = {hdr_body, frm_fd};
    head_cmd   = hdr_cmd | (32'(vb_now) << VB_POS);
    head_ack   = ack_byte(frm_flag, hdr_ack);
    pub_data   = PUB_TAG | 32'(pi_now) | (32'(vb_now) << VB_POS);
  end

endmodule

// File: rtl/rvb_enq_chk.sv
module rvb_enq_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CNT_W = 8,
  localparam int unsigned SLOT_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              body_we,
  input logic              head_we,
  input logic [SLOT_W-1:0] slot,
  input logic              pub_we,
  input logic [31:0]       pub_data,
  input logic              done,
  input logic [CNT_W-1:0]  done_count,
  input logic              vb_now
);

  logic head_seen;

  always_ff @(posedge clk) begin
    if (rst)          head_seen <= 1'b0;
    else if (done)    head_seen <= 1'b0;
    else if (head_we) head_seen <= 1'b1;
  end

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (rst)
    (body_we || head_we || done) |-> !req_ready);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_body_before_head_r6: assert property (@(posedge clk) disable iff (rst)
    body_we |-> !head_seen);

  p_head_slot_step_r7: assert property (@(posedge clk) disable iff (rst)
    (head_we && $past(head_we)) |-> (slot == SLOT_W'($past(slot) + 1'b1)));

  p_phase_flip_r7: assert property (@(posedge clk) disable iff (rst)
    (head_we && (slot == {SLOT_W{1'b1}})) |=> (vb_now != $past(vb_now)));

  p_pub_form_r9: assert property (@(posedge clk) disable iff (rst)
    pub_we |-> (done && pub_data[8] && (pub_data[31:9] == '0)));

  p_zero_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (done && (done_count == '0)) |-> !pub_we);

  p_grant_cap_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> (32'(done_count) <= DEPTH));

endmodule

bind rvb_enq_top rvb_enq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .body_we    (body_we),
  .head_we    (head_we),
  .slot       (slot),
  .pub_we     (pub_we),
  .pub_data   (pub_data),
  .done       (done),
  .done_count (done_count),
  .vb_now     (vb_now)
);

// File: tb/rvb_enq_top_bench.sv
module rvb_enq_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int D = 8;
  localparam int CW = 8;
  localparam int HBW = 200;
  localparam int FDW = 256;
  localparam logic [31:0] HCMD = 32'h0000_0031;
  localparam logic [7:0]  HACK = 8'h2C;
  localparam logic [HBW-1:0] HBODY = {25{8'h5A}};

  // {requested count, consumer index offered, ack-flag pattern}
  localparam int NV = 8;
  localparam logic [23:0] VEC [NV] = '{
    {8'd3, 8'h0B, 8'h05},
    {8'd7, 8'h0B, 8'hAA},
    {8'd2, 8'h06, 8'hFF},
    {8'd4, 8'h0A, 8'h00},
    {8'd1, 8'h01, 8'h01},
    {8'd0, 8'h0F, 8'h00},
    {8'd8, 8'h0F, 8'h3C},
    {8'd8, 8'h09, 8'hC3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] init_pi = 32'h86;
  logic [31:0] init_ci = 32'h06;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [CW-1:0] req_count = '0;
  logic [31:0] ci_in = '0;
  logic [CW-1:0] frm_idx;
  logic [FDW-1:0] frm_fd;
  logic [31:0] frm_flag;
  logic body_we, head_we, pub_we, done;
  logic [2:0] slot;
  logic [HBW+FDW-1:0] body_data;
  logic [31:0] head_cmd, pub_data;
  logic [7:0] head_ack;
  logic [CW-1:0] done_count;

  logic [7:0]  pat_q = '0;
  logic [31:0] fd_seed = 32'h1234_0000;

  assign frm_fd   = {8{fd_seed ^ {24'd0, frm_idx}}};
  assign frm_flag = {pat_q[frm_idx[2:0]], 27'd0, frm_idx[3:0] + 4'd5};

  int nchk = 0;
  int nbad = 0;
  int m_pi, m_vb, m_ci, m_avail;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rvb_enq_top #(.DEPTH(D), .CNT_W(CW), .HDR_BODY_W(HBW), .FD_W(FDW)) u_rvb_enq_top (
    .clk(clk), .rst(rst), .init_pi(init_pi), .init_ci(init_ci),
    .req_valid(req_valid), .req_ready(req_ready), .req_count(req_count),
    .hdr_cmd(HCMD), .hdr_ack(HACK), .hdr_body(HBODY), .ci_in(ci_in),
    .frm_idx(frm_idx), .frm_fd(frm_fd), .frm_flag(frm_flag),
    .body_we(body_we), .head_we(head_we), .slot(slot), .body_data(body_data),
    .head_cmd(head_cmd), .head_ack(head_ack), .pub_we(pub_we), .pub_data(pub_data),
    .done(done), .done_count(done_count)
  );

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [31:0] ipi, input logic [31:0] ici);
    @(negedge clk);
    rst = 1'b1; init_pi = ipi; init_ci = ici;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_pi = int'(ipi & 32'hF); m_vb = int'(ipi[7]); m_ci = int'(ici & 32'hF); m_avail = D;
    @(negedge clk);
    chk(req_ready && !done && !body_we && !head_we && !pub_we, "R1 idle after reset",
        {req_ready, done, body_we, head_we, pub_we}, 5'b10000);
  endtask

  task automatic run_batch(input int cnt, input int ci, input logic [7:0] pat);
    int n, bk, hk, es, ex;
    bit seen;
    if (m_avail == 0) begin
      m_avail = ((ci & 15) - m_ci + 2 * D) % (2 * D);   // R2 wrapped distance
      m_ci = ci & 15;
    end
    n = (m_avail < cnt) ? m_avail : cnt;
    m_avail -= n;
    pat_q = pat; fd_seed = fd_seed + 32'h0001_0000;
    req_valid = 1'b1; req_count = CW'(cnt); ci_in = 32'(ci);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; ci_in = 32'hFFFF_FFFF;
    bk = 0; hk = 0; seen = 0;
    for (int cyc = 0; cyc < 40 && !seen; cyc++) begin
      if (body_we) begin
        chk(!req_ready, "R10 ready low while busy", req_ready, 0);
        chk(hk == 0, "R6 body after head", hk, 0);
        es = (m_pi + bk) % D;
        chk(slot == 3'(es), "R5 body slot", slot, es);
        chk(body_data == {HBODY, {8{fd_seed ^ 32'(bk)}}}, "R5 body data",
            body_data, {HBODY, {8{fd_seed ^ 32'(bk)}}});
        bk++;
      end
      if (head_we) begin
        chk(bk == n, "R6 all bodies first", bk, n);
        es = (m_pi + hk) % D;
        chk(slot == 3'(es), "R7 head slot", slot, es);
        chk(head_cmd == (HCMD | 32'(m_vb << 7)), "R7 phase in command word",
            head_cmd, HCMD | 32'(m_vb << 7));
        ex = pat[hk] ? (8'h80 | ((hk + 5) & 15)) : HACK;
        chk(head_ack == 8'(ex), "R8 ack byte", head_ack, ex);
        if (((m_pi + hk + 1) % D) == 0) m_vb ^= 1;
        hk++;
      end
      if (done) begin
        seen = 1;
        chk(done_count == CW'(n), "R2/R4 accepted count", done_count, n);
        chk(hk == n, "R6 head count", hk, n);
        m_pi = (m_pi + n) % (2 * D);
        ex = 32'h100 | m_pi | (m_vb << 7);
        if (n > 0) chk(pub_we && pub_data == 32'(ex), "R9 publish", {pub_we, pub_data},
                       {1'b1, 32'(ex)});
        else       chk(!pub_we, "R3 no publish on zero", pub_we, 0);
      end
      @(negedge clk);
    end
    chk(seen, "R10 done seen", seen, 1);
    chk(!done, "R10 done one cycle", done, 0);
  endtask

  initial begin
    do_reset(32'h86, 32'h06);
    for (int v = 0; v < NV; v++)
      run_batch(int'(VEC[v][23:16]), int'(VEC[v][15:8]), VEC[v][7:0]);
    // Second reset: start just below index top, wrap and phase flip in one batch.
    do_reset(32'h0F, 32'h07);
    run_batch(2, 0, 8'h02);
    chk(m_pi == 1 && m_vb == 1, "R7 model wrap", {m_pi, m_vb}, {32'd1, 32'd1});
    run_batch(9, 3, 8'h00);  // R4 clipped at remaining free count
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nbad + 1);
    $finish;
  end

endmodule